// File: doc/BRIEF.md
# Paged Nibble Data Memory with Indexed Ports

This block is the 4-bit-wide data store of a small controller. Storage is split into six pages. A 6-bit offset selects a nibble within a page, and a page register holds the current page. The lowest eight offsets of every page are not page storage. They reach one shared window of eight nibble registers that reads the same whatever page is selected. The contents of that window are always visible on a flat output bus. The remaining 56 offsets of each page hold general storage, giving 336 nibbles in total.

There are three ways into the memory. The direct port takes a 6-bit offset, which is combined with the current page. Each of the two indexed ports builds its offset from two pointer nibbles: the low pointer gives the lower four bits and the two low bits of the high pointer give the upper two bits. The page register then completes the address. An indexed access whose offset falls in the lowest eight lands in the shared window, just as a direct access does.

All reads are combinational from the address. All writes, and page changes, take effect on the rising clock edge.

Top module: `paged_nibble_mem`

## Requirements
- R1: After synchronous reset the page register reads 0 and all eight window nibbles read 0.
- R2: A page write with a value from 0 to 5 loads the page register at the next rising edge. The page register only ever holds 0 to 5.
- R3: A page write with the value 6 or 7 is ignored. The page register and the data seen through the ports stay unchanged.
- R4: Direct offsets 0x08 to 0x3F address paged storage. A nibble written at an offset on one page leaves the same offset on every other page untouched.
- R5: Offsets 0x00 to 0x07 reach the same window register on every page. Window register i appears on `win_regs` bits [4i+3:4i].
- R6: Indexed port 0 addresses the offset {ptr1[1:0], ptr0} on the current page, for both reads and writes.
- R7: Indexed port 1 addresses the offset {ptr3[1:0], ptr2} on the current page, for both reads and writes.
- R8: An indexed offset from 0x00 to 0x07 reads and writes the shared window, not paged storage.
- R9: Read data follows the address in the same cycle. A write becomes visible only after the next rising edge.
- R10: When several ports write the same location in one cycle, the direct port wins over indexed port 0, and indexed port 0 wins over indexed port 1.
- R11: A memory write in the same cycle as a page change lands on the page that was current before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_addr | input | 6 | Direct offset within the current page |
| dir_wdata | input | 4 | Direct write data |
| dir_we | input | 1 | Direct write enable |
| dir_rdata | output | 4 | Direct read data (combinational) |
| page_we | input | 1 | Page register write strobe |
| page_wdata | input | 3 | New page number |
| page_cur | output | 3 | Current page |
| ix0_ptr_lo | input | 4 | Port 0 low pointer (offset bits 3:0) |
| ix0_ptr_hi | input | 2 | Port 0 high pointer bits (offset bits 5:4) |
| ix0_wdata | input | 4 | Port 0 write data |
| ix0_we | input | 1 | Port 0 write enable |
| ix0_rdata | output | 4 | Port 0 read data (combinational) |
| ix1_ptr_lo | input | 4 | Port 1 low pointer (offset bits 3:0) |
| ix1_ptr_hi | input | 2 | Port 1 high pointer bits (offset bits 5:4) |
| ix1_wdata | input | 4 | Port 1 write data |
| ix1_we | input | 1 | Port 1 write enable |
| ix1_rdata | output | 4 | Port 1 read data (combinational) |
| win_regs | output | 32 | Eight window nibbles, nibble i at bits [4i+3:4i] |

## Verification
Read data depends on the address with no register in the path, so it is due in the same cycle the address changes. Writes and page updates are due one rising edge after the strobe. The bench drives every input on the falling edge and samples read data one time unit after the address is applied. It checks written values only after the following rising edge. For R9 it also samples in the window between the strobe and the edge, to confirm that the old value is still visible there.

// File: rtl/pnm_pkg.sv
package pnm_pkg;

  // Default geometry shared by the block and its checker
  localparam int PNM_DW    = 4;  // data nibble width
  localparam int PNM_OFF_W = 6;  // offset width within a page
  localparam int PNM_PG_W  = 3;  // page register width
  localparam int PNM_PAGES = 6;  // number of legal pages
  localparam int PNM_WIN_N = 8;  // shared window registers
  localparam int PNM_PTR_W = 4;  // low pointer width

  // Port order is also write priority: lower value wins
  typedef enum logic [1:0] {
    PORT_DIR = 2'd0,
    PORT_IX0 = 2'd1,
    PORT_IX1 = 2'd2
  } pnm_port_e;

  localparam int PNM_NPORT = 3;

endpackage

// File: rtl/pnm_page_reg.sv
module pnm_page_reg #(
  parameter int PG_W  = 3,
  parameter int PAGES = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [PG_W-1:0] wdata,
  output logic [PG_W-1:0] page
);

  logic legal;
  assign legal = (wdata < PG_W'(PAGES));

  always_ff @(posedge clk) begin
    if (rst) begin
      page <= '0;
    end else if (we && legal) begin
      page <= wdata;
    end
  end

endmodule

// File: rtl/pnm_addr_map.sv
module pnm_addr_map #(
  parameter int OFF_W = 6,
  parameter int PG_W  = 3,
  parameter int WIN_N = 8,
  parameter int IDX_W = 9
) (
  input  logic [PG_W-1:0]          page,
  input  logic [OFF_W-1:0]         offset,
  output logic                     is_win,
  output logic [$clog2(WIN_N)-1:0] win_idx,
  output logic [IDX_W-1:0]         ram_idx
);

  localparam int WIN_W      = $clog2(WIN_N);
  localparam int PAGE_WORDS = (1 << OFF_W) - WIN_N;

  always_comb begin
    is_win  = (offset < OFF_W'(WIN_N));
    win_idx = offset[WIN_W-1:0];
    if (is_win) begin
      ram_idx = '0;
    end else begin
      ram_idx = IDX_W'(page) * IDX_W'(PAGE_WORDS)
              + IDX_W'(offset) - IDX_W'(WIN_N);
    end
  end

endmodule

// File: rtl/pnm_store.sv
module pnm_store #(
  parameter int DW    = 4,
  parameter int DEPTH = 336,
  parameter int IDX_W = 9,
  parameter int WIN_N = 8,
  parameter int NPORT = 3
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NPORT-1:0]                      we,
  input  logic [NPORT-1:0]                      is_win,
  input  logic [NPORT-1:0][$clog2(WIN_N)-1:0]   win_idx,
  input  logic [NPORT-1:0][IDX_W-1:0]           ram_idx,
  input  logic [NPORT-1:0][DW-1:0]              wdata,
  output logic [NPORT-1:0][DW-1:0]              rdata,
  output logic [WIN_N-1:0][DW-1:0]              win_q
);

  logic [DW-1:0] ram [DEPTH];

  // Paged storage: no reset; the highest-numbered port is applied first
  // so that port 0 lands last and wins a collision.
  always_ff @(posedge clk) begin
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (we[p] && !is_win[p]) begin
        ram[ram_idx[p]] <= wdata[p];
      end
    end
  end

  // Shared window registers, reset to zero, same priority order
  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else begin
      for (int p = NPORT - 1; p >= 0; p--) begin
        if (we[p] && is_win[p]) begin
          win_q[win_idx[p]] <= wdata[p];
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      rdata[p] = is_win[p] ? win_q[win_idx[p]] : ram[ram_idx[p]];
    end
  end

endmodule

// File: rtl/paged_nibble_mem.sv
module paged_nibble_mem
  import pnm_pkg::*;
#(
  parameter int DW    = PNM_DW,
  parameter int OFF_W = PNM_OFF_W,
  parameter int PG_W  = PNM_PG_W,
  parameter int PAGES = PNM_PAGES,
  parameter int WIN_N = PNM_WIN_N,
  parameter int PTR_W = PNM_PTR_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [OFF_W-1:0]       dir_addr,
  input  logic [DW-1:0]          dir_wdata,
  input  logic                   dir_we,
  output logic [DW-1:0]          dir_rdata,
  input  logic                   page_we,
  input  logic [PG_W-1:0]        page_wdata,
  output logic [PG_W-1:0]        page_cur,
  input  logic [PTR_W-1:0]       ix0_ptr_lo,
  input  logic [OFF_W-PTR_W-1:0] ix0_ptr_hi,
  input  logic [DW-1:0]          ix0_wdata,
  input  logic                   ix0_we,
  output logic [DW-1:0]          ix0_rdata,
  input  logic [PTR_W-1:0]       ix1_ptr_lo,
  input  logic [OFF_W-PTR_W-1:0] ix1_ptr_hi,
  input  logic [DW-1:0]          ix1_wdata,
  input  logic                   ix1_we,
  output logic [DW-1:0]          ix1_rdata,
  output logic [WIN_N*DW-1:0]    win_regs
);

  localparam int NPORT      = PNM_NPORT;
  localparam int WIN_W      = $clog2(WIN_N);
  localparam int PAGE_WORDS = (1 << OFF_W) - WIN_N;
  localparam int DEPTH      = PAGES * PAGE_WORDS;
  localparam int IDX_W      = $clog2(DEPTH);

  logic [NPORT-1:0][OFF_W-1:0] port_off;
  logic [NPORT-1:0]            port_we;
  logic [NPORT-1:0][DW-1:0]    port_wd;
  logic [NPORT-1:0][DW-1:0]    port_rd;
  logic [NPORT-1:0]            port_win;
  logic [NPORT-1:0][WIN_W-1:0] port_widx;
  logic [NPORT-1:0][IDX_W-1:0] port_ridx;
  logic [WIN_N-1:0][DW-1:0]    win_q;

  // Offsets: direct as given, indexed by concatenating pointer fields
  assign port_off[PORT_DIR] = dir_addr;
  assign port_off[PORT_IX0] = {ix0_ptr_hi, ix0_ptr_lo};
  assign port_off[PORT_IX1] = {ix1_ptr_hi, ix1_ptr_lo};

  assign port_we[PORT_DIR]  = dir_we;
  assign port_we[PORT_IX0]  = ix0_we;
  assign port_we[PORT_IX1]  = ix1_we;

  assign port_wd[PORT_DIR]  = dir_wdata;
  assign port_wd[PORT_IX0]  = ix0_wdata;
  assign port_wd[PORT_IX1]  = ix1_wdata;

  pnm_page_reg #(
    .PG_W (PG_W),
    .PAGES(PAGES)
  ) u_page (
    .clk  (clk),
    .rst  (rst),
    .we   (page_we),
    .wdata(page_wdata),
    .page (page_cur)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_map
    pnm_addr_map #(
      .OFF_W(OFF_W),
      .PG_W (PG_W),
      .WIN_N(WIN_N),
      .IDX_W(IDX_W)
    ) u_map (
      .page   (page_cur),
      .offset (port_off[g]),
      .is_win (port_win[g]),
      .win_idx(port_widx[g]),
      .ram_idx(port_ridx[g])
    );
  end

  pnm_store #(
    .DW   (DW),
    .DEPTH(DEPTH),
    .IDX_W(IDX_W),
    .WIN_N(WIN_N),
    .NPORT(NPORT)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .we     (port_we),
    .is_win (port_win),
    .win_idx(port_widx),
    .ram_idx(port_ridx),
    .wdata  (port_wd),
    .rdata  (port_rd),
    .win_q  (win_q)
  );

  assign dir_rdata = port_rd[PORT_DIR];
  assign ix0_rdata = port_rd[PORT_IX0];
  assign ix1_rdata = port_rd[PORT_IX1];
  assign win_regs  = win_q;

endmodule

// File: rtl/pnm_checker.sv
module pnm_checker #(
  parameter int DW    = 4,
  parameter int OFF_W = 6,
  parameter int PG_W  = 3,
  parameter int PAGES = 6,
  parameter int WIN_N = 8,
  parameter int PTR_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [OFF_W-1:0]       dir_addr,
  input logic [DW-1:0]          dir_wdata,
  input logic                   dir_we,
  input logic [DW-1:0]          dir_rdata,
  input logic                   page_we,
  input logic [PG_W-1:0]        page_wdata,
  input logic [PG_W-1:0]        page_cur,
  input logic [PTR_W-1:0]       ix0_ptr_lo,
  input logic [OFF_W-PTR_W-1:0] ix0_ptr_hi,
  input logic [DW-1:0]          ix0_wdata,
  input logic                   ix0_we,
  input logic [DW-1:0]          ix0_rdata,
  input logic [PTR_W-1:0]       ix1_ptr_lo,
  input logic [OFF_W-PTR_W-1:0] ix1_ptr_hi,
  input logic [DW-1:0]          ix1_wdata,
  input logic                   ix1_we,
  input logic [DW-1:0]          ix1_rdata,
  input logic [WIN_N*DW-1:0]    win_regs
);

  localparam int WIN_W = $clog2(WIN_N);

  logic [OFF_W-1:0] ix0_off;
  assign ix0_off = {ix0_ptr_hi, ix0_ptr_lo};

  // Remember the last direct window write to compare one edge later
  logic             prev_win_we;
  logic [WIN_W-1:0] prev_win_idx;
  logic [DW-1:0]    prev_win_dat;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_win_we  <= 1'b0;
      prev_win_idx <= '0;
      prev_win_dat <= '0;
    end else begin
      prev_win_we  <= dir_we && (dir_addr < OFF_W'(WIN_N));
      prev_win_idx <= dir_addr[WIN_W-1:0];
      prev_win_dat <= dir_wdata;
    end
  end

  // R2
  page_range_chk: assert property (@(posedge clk) disable iff (rst)
    page_cur < PG_W'(PAGES));

  // R2
  page_load_chk: assert property (@(posedge clk) disable iff (rst)
    (page_we && page_wdata < PG_W'(PAGES)) |=> page_cur == $past(page_wdata));

  // R3
  page_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (page_we && page_wdata >= PG_W'(PAGES)) |=> $stable(page_cur));

  // R5
  win_write_chk: assert property (@(posedge clk) disable iff (rst)
    prev_win_we |-> win_regs[prev_win_idx*DW +: DW] == prev_win_dat);

  // R8
  ix0_win_read_chk: assert property (@(posedge clk) disable iff (rst)
    (ix0_off < OFF_W'(WIN_N)) |-> ix0_rdata == win_regs[ix0_off[WIN_W-1:0]*DW +: DW]);

  // R9
  dir_raw_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_we && dir_addr >= OFF_W'(WIN_N) && !page_we)
      |=> (!$stable(dir_addr) || dir_rdata == $past(dir_wdata)));

endmodule

bind paged_nibble_mem pnm_checker #(
  .DW   (DW),
  .OFF_W(OFF_W),
  .PG_W (PG_W),
  .PAGES(PAGES),
  .WIN_N(WIN_N),
  .PTR_W(PTR_W)
) u_pnm_chk (.*);

// File: tb/paged_nibble_mem_test.sv
module paged_nibble_mem_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] dir_addr;
  logic [3:0] dir_wdata;
  logic       dir_we;
  logic [3:0] dir_rdata;
  logic       page_we;
  logic [2:0] page_wdata;
  logic [2:0] page_cur;
  logic [3:0] ix0_ptr_lo, ix1_ptr_lo;
  logic [1:0] ix0_ptr_hi, ix1_ptr_hi;
  logic [3:0] ix0_wdata, ix1_wdata;
  logic       ix0_we, ix1_we;
  logic [3:0] ix0_rdata, ix1_rdata;
  logic [31:0] win_regs;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model
  logic [3:0] m_ram [6][64];
  logic [3:0] m_win [8];
  int         m_page;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_nibble_mem uut (
    .clk(clk), .rst(rst),
    .dir_addr(dir_addr), .dir_wdata(dir_wdata), .dir_we(dir_we), .dir_rdata(dir_rdata),
    .page_we(page_we), .page_wdata(page_wdata), .page_cur(page_cur),
    .ix0_ptr_lo(ix0_ptr_lo), .ix0_ptr_hi(ix0_ptr_hi), .ix0_wdata(ix0_wdata),
    .ix0_we(ix0_we), .ix0_rdata(ix0_rdata),
    .ix1_ptr_lo(ix1_ptr_lo), .ix1_ptr_hi(ix1_ptr_hi), .ix1_wdata(ix1_wdata),
    .ix1_we(ix1_we), .ix1_rdata(ix1_rdata),
    .win_regs(win_regs)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expect_at(input int pg, input int off);
    return (off < 8) ? int'(m_win[off]) : int'(m_ram[pg][off]);
  endfunction

  function automatic void model_wr(input int pg, input int off, input int d);
    if (off < 8) m_win[off] = 4'(d);
    else         m_ram[pg][off] = 4'(d);
  endfunction

  task automatic set_page(input int v);
    @(negedge clk);
    page_wdata = 3'(v);
    page_we = 1'b1;
    @(negedge clk);
    page_we = 1'b0;
    if (v < 6) m_page = v;
  endtask

  task automatic wr_dir(input int a, input int d);
    @(negedge clk);
    dir_addr = 6'(a);
    dir_wdata = 4'(d);
    dir_we = 1'b1;
    @(negedge clk);
    dir_we = 1'b0;
    model_wr(m_page, a, d);
  endtask

  task automatic rd_dir(input string tag, input int a);
    dir_addr = 6'(a);
    #1;
    check(tag, int'(dir_rdata), expect_at(m_page, a));
  endtask

  task automatic set_ix(input int o0, input int o1);
    ix0_ptr_lo = o0[3:0]; ix0_ptr_hi = o0[5:4];
    ix1_ptr_lo = o1[3:0]; ix1_ptr_hi = o1[5:4];
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    dir_addr = '0; dir_wdata = '0; dir_we = 1'b0;
    page_we = 1'b0; page_wdata = '0;
    ix0_wdata = '0; ix1_wdata = '0; ix0_we = 1'b0; ix1_we = 1'b0;
    set_ix(0, 0);
    m_page = 0;
    for (int i = 0; i < 8; i++) m_win[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1", int'(page_cur), 0);
    check("R1", int'(win_regs), 0);

    // R2 / R4: fill every page through the direct port
    for (int p = 0; p < 6; p++) begin
      set_page(p);
      check("R2", int'(page_cur), p);
      for (int o = 8; o < 64; o++) wr_dir(o, (p * 7 + o * 3 + 1) & 15);
    end
    // R4: each page holds its own pattern
    for (int p = 0; p < 6; p++) begin
      set_page(p);
      for (int o = 8; o < 64; o++) rd_dir("R4", o);
    end

    // R5: window shared across pages and mirrored on win_regs
    set_page(3);
    for (int o = 0; o < 8; o++) wr_dir(o, (o * 5 + 2) & 15);
    set_page(0);
    for (int o = 0; o < 8; o++) begin
      rd_dir("R5", o);
      check("R5", int'(win_regs[o*4 +: 4]), (o * 5 + 2) & 15);
    end

    // R3: illegal page values are ignored
    set_page(2);
    set_page(6);
    #1;
    check("R3", int'(page_cur), 2);
    rd_dir("R3", 16'h10);
    set_page(7);
    #1;
    check("R3", int'(page_cur), 2);
    rd_dir("R3", 6'h3f);

    // R6 / R7 / R8: indexed read sweeps on two pages
    for (int k = 0; k < 2; k++) begin
      set_page(k == 0 ? 1 : 4);
      for (int o = 0; o < 64; o++) begin
        set_ix(o, 63 - o);
        #1;
        check((o < 8) ? "R8" : "R6", int'(ix0_rdata), expect_at(m_page, o));
        check((63 - o < 8) ? "R8" : "R7", int'(ix1_rdata), expect_at(m_page, 63 - o));
      end
    end

    // R6 / R7 / R8: indexed writes on page 2
    set_page(2);
    @(negedge clk);
    set_ix(6'h20, 6'h31);
    ix0_wdata = 4'hA; ix1_wdata = 4'h5;
    ix0_we = 1'b1; ix1_we = 1'b1;
    @(negedge clk);
    ix0_we = 1'b0; ix1_we = 1'b0;
    model_wr(2, 6'h20, 4'hA);
    model_wr(2, 6'h31, 4'h5);
    rd_dir("R6", 6'h20);
    rd_dir("R7", 6'h31);
    set_page(5);
    rd_dir("R6", 6'h20);
    set_page(2);
    @(negedge clk);
    set_ix(3, 6);
    ix0_wdata = 4'hC; ix1_wdata = 4'h9;
    ix0_we = 1'b1; ix1_we = 1'b1;
    @(negedge clk);
    ix0_we = 1'b0; ix1_we = 1'b0;
    model_wr(2, 3, 4'hC);
    model_wr(2, 6, 4'h9);
    #1;
    check("R8", int'(win_regs[12 +: 4]), 4'hC);
    check("R8", int'(win_regs[24 +: 4]), 4'h9);

    // R9: same-cycle read, write visible only after the edge
    @(negedge clk);
    dir_addr = 6'h15;
    #1;
    check("R9", int'(dir_rdata), expect_at(2, 6'h15));
    dir_wdata = 4'((expect_at(2, 6'h15) + 1) & 15);
    dir_we = 1'b1;
    #1;
    check("R9", int'(dir_rdata), expect_at(2, 6'h15));
    @(negedge clk);
    dir_we = 1'b0;
    model_wr(2, 6'h15, int'(dir_wdata));
    rd_dir("R9", 6'h15);

    // R10: write collisions
    @(negedge clk);
    dir_addr = 6'h22; dir_wdata = 4'h1; dir_we = 1'b1;
    set_ix(6'h22, 6'h22);
    ix0_wdata = 4'h2; ix1_wdata = 4'h3; ix0_we = 1'b1; ix1_we = 1'b1;
    @(negedge clk);
    dir_we = 1'b0; ix0_we = 1'b0; ix1_we = 1'b0;
    model_wr(2, 6'h22, 4'h1);
    rd_dir("R10", 6'h22);
    @(negedge clk);
    set_ix(6'h05, 6'h05);
    ix0_wdata = 4'h7; ix1_wdata = 4'hE; ix0_we = 1'b1; ix1_we = 1'b1;
    @(negedge clk);
    ix0_we = 1'b0; ix1_we = 1'b0;
    model_wr(2, 5, 4'h7);
    #1;
    check("R10", int'(win_regs[20 +: 4]), 4'h7);

    // R11: page change and write in the same cycle
    @(negedge clk);
    page_wdata = 3'd4; page_we = 1'b1;
    dir_addr = 6'h30; dir_wdata = 4'(~expect_at(2, 6'h30)); dir_we = 1'b1;
    @(negedge clk);
    page_we = 1'b0; dir_we = 1'b0;
    model_wr(2, 6'h30, int'(dir_wdata));
    m_page = 4;
    #1;
    check("R11", int'(page_cur), 4);
    rd_dir("R11", 6'h30);
    set_page(2);
    rd_dir("R11", 6'h30);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule